// File: doc/BRIEF.md
# Four-Row Rotating Window Buffer

This block keeps image rows on chip for a 3x3 neighbourhood operation. Pixels arrive as a raster stream, one per handshake, and fill four one-row memories in turn. As soon as three complete rows are held, a consumer can pull columns out: every accepted read returns the pixel at the same column from the three oldest rows at once. The oldest row comes out on the top tap and the newest of the three on the bottom tap.

When a whole row of columns has been read, the oldest stored row is released and the three-row window moves down by one row. The rows stay in their memories. Only a rotating select pointer moves, so every image row crosses the input port exactly once and can serve up to three output rows. The fourth memory lets the next row load while the current three are being read. A level interrupt marks each finished output row so that the processor can queue the next input row. It stays high until the processor clears it.

Top module: `row_window_buffer`

## Requirements
- R1: After a synchronous reset, in_ready is 1, and win_ready, out_valid and irq are 0.
- R2: A pixel is accepted on a rising edge where in_valid and in_ready are both 1. Accepted pixels fill row n at columns 0 to LINE_LEN-1 in arrival order, and then row n+1 starts. Rows are numbered from 0 after reset.
- R3: in_ready is 0 exactly when four complete rows are held that have not yet been released. A pixel offered in that state is not taken.
- R4: win_ready is 1 exactly when at least three complete unreleased rows are held. A read request (rd_en) while win_ready is 0 is ignored and produces no out_valid.
- R5: A read is accepted on an edge where rd_en and win_ready are both 1. Its result appears with out_valid=1 after the next rising edge. Otherwise out_valid is 0.
- R6: For a read of column c while the window holds rows r, r+1 and r+2, line_top carries pixel (r,c), line_mid carries (r+1,c) and line_bot carries (r+2,c).
- R7: Accepted reads walk the columns 0 to LINE_LEN-1. The read of the last column completes the output row and releases row r. The next read returns column 0 of rows r+1 to r+3.
- R8: irq rises on the edge that completes an output row and stays at 1 until an edge with irq_clr=1. A completion on the same edge as a clear leaves irq at 1.
- R9: While exactly three complete rows are held, in_ready stays 1, so the next row loads while the window is being read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel present |
| in_pixel | input | PIX_W | Input pixel value |
| in_ready | output | 1 | A free row memory can take the pixel |
| win_ready | output | 1 | Three complete rows available for reading |
| rd_en | input | 1 | Request one column of the window |
| out_valid | output | 1 | Taps carry a read result |
| line_top | output | PIX_W | Column pixel of the oldest row in the window |
| line_mid | output | PIX_W | Column pixel of the middle row |
| line_bot | output | PIX_W | Column pixel of the newest row in the window |
| irq | output | 1 | Output-row-finished flag |
| irq_clr | input | 1 | Clears irq |

## Verification
The bench builds the block with PIX_W=8 and LINE_LEN=8. With rows that short, a run of a few thousand cycles covers many output rows. The modulo-4 write and window pointers therefore wrap many times, and the full-stall state, the three-row overlap state and the empty-window state are each entered repeatedly. Random gaps on both the input and the read side reach combinations such as a row load finishing on the same edge as a row release. Random clear pulses sometimes land on a completion edge, which exercises the case where setting irq takes priority over clearing it.

// File: rtl/rwb_pkg.sv
package rwb_pkg;
  // rotation is defined over exactly four row memories
  localparam int NBUF = 4;
  localparam int NTAP = 3;
  typedef logic [1:0] bufsel_t;
endpackage

// File: rtl/rwb_row_ram.sv
module rwb_row_ram #(
  parameter int PIX_W = 8,
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [PIX_W-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [PIX_W-1:0] rdata
);
  logic [PIX_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rwb_wr_ctrl.sv
module rwb_wr_ctrl
  import rwb_pkg::*;
#(
  parameter int LINE_LEN = 512,
  localparam int AW = $clog2(LINE_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          space,
  output logic          wr_acc,
  output bufsel_t       wr_ptr,
  output logic [AW-1:0] wr_col,
  output logic          line_done
);
  localparam logic [AW-1:0] LAST = AW'(LINE_LEN - 1);

  assign wr_acc    = in_valid && space;
  assign line_done = wr_acc && (wr_col == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      wr_col <= '0;
    end else if (wr_acc) begin
      if (wr_col == LAST) begin
        wr_col <= '0;
        wr_ptr <= wr_ptr + 2'd1;
      end else begin
        wr_col <= wr_col + AW'(1);
      end
    end
  end
endmodule

// File: rtl/rwb_rd_ctrl.sv
module rwb_rd_ctrl
  import rwb_pkg::*;
#(
  parameter int LINE_LEN = 512,
  localparam int AW = $clog2(LINE_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic          avail,
  input  logic          irq_clr,
  output logic          rd_acc,
  output logic [AW-1:0] rd_col,
  output bufsel_t       base,
  output logic          row_done,
  output logic          irq
);
  localparam logic [AW-1:0] LAST = AW'(LINE_LEN - 1);

  assign rd_acc   = rd_en && avail;
  assign row_done = rd_acc && (rd_col == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_col <= '0;
      base   <= '0;
      irq    <= 1'b0;
    end else begin
      if (rd_acc) begin
        if (rd_col == LAST) begin
          rd_col <= '0;
          base   <= base + 2'd1;
        end else begin
          rd_col <= rd_col + AW'(1);
        end
      end
      if (row_done)     irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
    end
  end
endmodule

// File: rtl/rwb_tap_mux.sv
module rwb_tap_mux
  import rwb_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       vld,
  input  bufsel_t                    sel,
  input  logic [NBUF-1:0][PIX_W-1:0] q,
  output logic                       out_valid,
  output logic [NTAP-1:0][PIX_W-1:0] taps
);
  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= vld;
  end

  always_ff @(posedge clk) begin
    if (vld) begin
      for (int t = 0; t < NTAP; t++) begin
        taps[t] <= q[bufsel_t'(sel + 2'(t))];
      end
    end
  end
endmodule

// File: rtl/row_window_buffer.sv
module row_window_buffer
  import rwb_pkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int LINE_LEN = 512
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] in_pixel,
  output logic             in_ready,
  output logic             win_ready,
  input  logic             rd_en,
  output logic             out_valid,
  output logic [PIX_W-1:0] line_top,
  output logic [PIX_W-1:0] line_mid,
  output logic [PIX_W-1:0] line_bot,
  output logic             irq,
  input  logic             irq_clr
);
  localparam int AW = $clog2(LINE_LEN);
  localparam int CW = $clog2(NBUF + 1);

  logic [CW-1:0]              occ;
  logic                       space, avail;
  logic                       wr_acc, line_done, rd_acc, row_done;
  bufsel_t                    wr_ptr, base, sel_d1;
  logic [AW-1:0]              wr_col, rd_col;
  logic [NBUF-1:0]            ram_we;
  logic [NBUF-1:0][PIX_W-1:0] ram_q;
  logic [NTAP-1:0][PIX_W-1:0] taps;
  logic                       vld_d1;

  assign space     = (occ != CW'(NBUF));
  assign avail     = (occ >= CW'(NTAP));
  assign in_ready  = space;
  assign win_ready = avail;

  always_ff @(posedge clk) begin
    if (rst) occ <= '0;
    else     occ <= occ + CW'(line_done) - CW'(row_done);
  end

  rwb_wr_ctrl #(.LINE_LEN(LINE_LEN)) u_wr (
    .clk(clk), .rst(rst), .in_valid(in_valid), .space(space),
    .wr_acc(wr_acc), .wr_ptr(wr_ptr), .wr_col(wr_col), .line_done(line_done)
  );

  rwb_rd_ctrl #(.LINE_LEN(LINE_LEN)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .avail(avail), .irq_clr(irq_clr),
    .rd_acc(rd_acc), .rd_col(rd_col), .base(base), .row_done(row_done), .irq(irq)
  );

  for (genvar b = 0; b < NBUF; b++) begin : g_row
    assign ram_we[b] = wr_acc && (wr_ptr == bufsel_t'(b));
    rwb_row_ram #(.PIX_W(PIX_W), .DEPTH(LINE_LEN)) u_ram (
      .clk(clk), .we(ram_we[b]), .waddr(wr_col), .wdata(in_pixel),
      .re(rd_acc), .raddr(rd_col), .rdata(ram_q[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) vld_d1 <= 1'b0;
    else     vld_d1 <= rd_acc;
  end

  always_ff @(posedge clk) begin
    if (rd_acc) sel_d1 <= base;
  end

  rwb_tap_mux #(.PIX_W(PIX_W)) u_mux (
    .clk(clk), .rst(rst), .vld(vld_d1), .sel(sel_d1), .q(ram_q),
    .out_valid(out_valid), .taps(taps)
  );

  assign line_top = taps[0];
  assign line_mid = taps[1];
  assign line_bot = taps[2];
endmodule

// File: rtl/rwb_checker.sv
module rwb_checker
  import rwb_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            in_ready,
  input logic            win_ready,
  input logic            rd_en,
  input logic            out_valid,
  input logic            irq,
  input logic            irq_clr,
  input logic            row_done,
  input logic [NBUF-1:0] ram_we,
  input bufsel_t         wr_ptr
);
  assert_single_write_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ram_we));

  assert_stall_needs_window_R3: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> win_ready);

  assert_stall_holds_ptr_R3: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> $stable(wr_ptr));

  assert_release_frees_R3: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && row_done) |=> in_ready);

  assert_result_has_cause_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($past(rd_en, 2) && $past(win_ready, 2)));

  assert_irq_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clr) |=> irq);

  assert_irq_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(row_done));

  assert_irq_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
    row_done |=> irq);
endmodule

bind row_window_buffer rwb_checker u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .win_ready(win_ready),
  .rd_en(rd_en), .out_valid(out_valid), .irq(irq), .irq_clr(irq_clr),
  .row_done(row_done), .ram_we(ram_we), .wr_ptr(wr_ptr)
);

// File: tb/row_window_buffer_test.sv
module row_window_buffer_test;
  localparam int PIX_W = 8;
  localparam int L     = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, rd_en = 1'b0, irq_clr = 1'b0;
  logic [PIX_W-1:0] in_pixel = '0;
  logic in_ready, win_ready, out_valid, irq;
  logic [PIX_W-1:0] line_top, line_mid, line_bot;

  always #2.5 clk = ~clk;

  row_window_buffer #(.PIX_W(PIX_W), .LINE_LEN(L)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_pixel(in_pixel),
    .in_ready(in_ready), .win_ready(win_ready), .rd_en(rd_en),
    .out_valid(out_valid), .line_top(line_top), .line_mid(line_mid),
    .line_bot(line_bot), .irq(irq), .irq_clr(irq_clr)
  );

  int total = 0, fails = 0;
  bit done = 0;

  // model state
  int wline = 0, wcol = 0, filled = 0, rrow = 0, rcol = 0;
  bit irq_m = 0;
  bit pv0 = 0, pv1 = 0;
  int prow0 = 0, pcol0 = 0, prow1 = 0, pcol1 = 0;

  function automatic logic [PIX_W-1:0] pix(int ln, int c);
    return PIX_W'(ln * 29 + c * 13 + ln * c + 7);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_outputs();
    chk(in_ready == (filled < 4), "R3 in_ready", in_ready, filled < 4);
    if (filled == 3) chk(in_ready == 1'b1, "R9 overlap in_ready", in_ready, 1);
    chk(win_ready == (filled >= 3), "R4 win_ready", win_ready, filled >= 3);
    chk(irq == irq_m, "R8 irq", irq, irq_m);
    chk(out_valid == pv1, "R5 out_valid", out_valid, pv1);
    if (pv1 && out_valid) begin
      chk(line_top == pix(prow1, pcol1), "R6 line_top", line_top, pix(prow1, pcol1));
      chk(line_mid == pix(prow1 + 1, pcol1), "R6 line_mid", line_mid, pix(prow1 + 1, pcol1));
      chk(line_bot == pix(prow1 + 2, pcol1), "R7 R2 line_bot", line_bot, pix(prow1 + 2, pcol1));
    end
  endtask

  // drive one cycle at the current negedge and predict the next edge
  task automatic step(int p_in, int p_rd, int p_clr);
    bit wacc, racc, rdone, ldone;
    in_valid = ($urandom % 100) < p_in;
    rd_en    = ($urandom % 100) < p_rd;
    irq_clr  = ($urandom % 100) < p_clr;
    in_pixel = pix(wline, wcol);
    wacc  = in_valid && (filled < 4);
    racc  = rd_en && (filled >= 3);
    ldone = wacc && (wcol == L - 1);
    rdone = racc && (rcol == L - 1);
    pv1 = pv0; prow1 = prow0; pcol1 = pcol0;
    pv0 = racc; prow0 = rrow; pcol0 = rcol;
    if (wacc) begin
      if (ldone) begin wcol = 0; wline++; end
      else wcol++;
    end
    if (racc) begin
      if (rdone) begin rcol = 0; rrow++; end
      else rcol++;
    end
    filled = filled + int'(ldone) - int'(rdone);
    if (rdone) irq_m = 1;
    else if (irq_clr) irq_m = 0;
    @(negedge clk);
    check_outputs();
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    chk(win_ready == 1'b0, "R1 win_ready", win_ready, 0);
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(irq == 1'b0, "R1 irq", irq, 0);
    // R4: reads requested while fewer than three rows exist
    for (int i = 0; i < 2 * L; i++) step(100, 100, 0);
    // R3: fill to four rows with no reads, then keep offering pixels
    for (int i = 0; i < 2 * L + 6; i++) step(100, 0, 0);
    // random mix
    for (int i = 0; i < 4000; i++) step(60, 60, 10);
    // reads only, then writes only
    for (int i = 0; i < 10 * L; i++) step(0, 80, 5);
    for (int i = 0; i < 6 * L; i++) step(90, 0, 30);
    for (int i = 0; i < 2000; i++) step(70, 70, 8);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog R1-chain actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule